// File: doc/BRIEF.md
# Clock-Generator Control Register Serial Slave

This block is the slave side of a two-wire serial control port that programs a small bank of eight 8-bit control registers inside a clock generator. A bus master addresses the block with the 7-bit address 0x69. On a write, two filler bytes follow the address byte: a command code and a byte count. Both are acknowledged and then thrown away. The data bytes after them fill the registers in order, starting at register 0. On a read, the block returns the registers in order, starting at register 0, straight after the address acknowledge. No pointer byte is sent.

The bus lines arrive asynchronously and are oversampled by the system clock. The slave pulls SDA low through an open-drain enable and never stretches the clock. All register contents are presented in parallel for the rest of the clock generator. The power-up reset loads the register defaults. Bus-level events such as START and STOP never touch the stored values.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) always returns the slave to address reception with the register pointer at 0. This includes a repeated START in the middle of a transfer. A STOP (SDA rising while SCL is high) ends the transfer.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged by driving SDA low for the ninth clock. Any other address byte is not acknowledged, and the slave then neither drives SDA nor stores anything until the next START or STOP.
- R3: In a write, the first two bytes after the address are acknowledged and never stored. A write that ends after them leaves every register unchanged.
- R4: Each write data byte is acknowledged and stored, the first in register 0 and each following byte in the next register. Bits are sent MSB first.
- R5: A read returns register 0 first and then the following registers in order, MSB first. The slave drives SDA low for each 0 bit and releases it for each 1 bit.
- R6: The register pointer stops at register 7. Further write bytes are acknowledged but change nothing and never wrap to register 0. Further read bytes repeat register 7.
- R7: Register 7 always reads 0x63, and writes to it are ignored.
- R8: The power-up reset sets registers 0 to 7 to 00, 00, 00, 00, 45, EF, 23 and 63 (hex). Register i appears on cfg_regs[8i+7:8i]. START and STOP leave the registers unchanged.
- R9: A master NACK after a read byte ends the read. SDA stays released until the next START.
- R10: The slave turns its SDA drive on only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high power-up reset; loads register defaults |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_regs | output | 64 | All eight registers, register i at bits [8i+7:8i] |

## Verification
Each pad change passes two synchroniser flops and one edge register. The drive enable and the register image therefore respond on the third clock after the pin moves, and a write lands on the third clock after the SCL fall that closes the eighth data bit. The bench holds every SCL phase for ten clocks. It samples SDA in the middle of each high phase, by which time the slave's drive has been stable for several clocks. The register image is compared against the behavioural model on every clock, except for the six clocks after any bus change, so the three-clock response always falls inside the skipped window.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    // Bus transfer phase of the slave
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_WDATA,
        PH_RDATA,
        PH_SKIP
    } phase_e;

    // Conditioned line levels and detected events
    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } line_evt_t;

    // Register write request from the bus engine to the storage
    typedef struct packed {
        logic                 en;
        logic [IDX_W-1:0]     idx;
        logic [REG_W-1:0]     data;
    } wr_req_t;

    // Saturating register pointer step
    function automatic logic [IDX_W-1:0] ptr_step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(NUM_REGS - 1)) ? p : p + 1'b1;
    endfunction

    // Value loaded at power-up reset
    function automatic logic [REG_W-1:0] power_default(input int unsigned idx);
        case (idx)
            4:       return 8'h45;
            5:       return 8'hEF;
            6:       return 8'h23;
            7:       return 8'h63;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clkcfg_line_sampler.sv
module clkcfg_line_sampler
    import clkcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_in,
    input  logic      sda_in,
    output line_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;
    logic                   sda_now;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= 1'b1;
                    sda_chain <= 1'b1;
                end else begin
                    scl_chain <= scl_in;
                    sda_chain <= sda_in;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_in};
                    sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_now = scl_chain[SYNC_STAGES-1];
    assign sda_now = sda_chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    always_comb begin
        evt.scl      = scl_now;
        evt.sda      = sda_now;
        evt.scl_rise = scl_now & ~scl_prev;
        evt.scl_fall = ~scl_now & scl_prev;
        evt.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        evt.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/clkcfg_reg_store.sv
module clkcfg_reg_store
    import clkcfg_pkg::*;
#(
    parameter logic [REG_W-1:0] ID_VALUE = 8'h63
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_req_t                       wr_req,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [REG_W-1:0]              rd_data,
    output logic [NUM_REGS*REG_W-1:0]     all_regs
);

    localparam int ID_INDEX = NUM_REGS - 1;

    logic [NUM_REGS-1:0][REG_W-1:0] bank;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            if (g == ID_INDEX) begin : g_ro
                // Identification register: fixed value, no storage
                assign bank[g] = ID_VALUE;
            end else begin : g_rw
                logic [REG_W-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= power_default(g);
                    end else if (wr_req.en && (wr_req.idx == IDX_W'(g))) begin
                        q <= wr_req.data;
                    end
                end
                assign bank[g] = q;
            end
        end
    endgenerate

    assign rd_data  = bank[rd_idx];
    assign all_regs = bank;

endmodule

// File: rtl/clkcfg_bus_engine.sv
module clkcfg_bus_engine
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst,
    input  line_evt_t        evt,
    input  logic [REG_W-1:0] rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output wr_req_t          wr_req,
    output logic             sda_drive_low,
    output phase_e           phase_o
);

    localparam logic [3:0] BYTE_BITS = 4'd8;

    phase_e           phase;
    logic             in_ack;
    logic             rw_q;
    logic             mnack;
    logic             drv;
    logic [3:0]       bitcnt;
    logic [REG_W-1:0] shreg;
    logic [IDX_W-1:0] ptr;

    logic receiving;
    logic byte_done;
    logic addr_hit;
    logic rd_bit;

    function automatic phase_e next_rx_phase(input phase_e p);
        case (p)
            PH_ADDR: return PH_CMD;
            PH_CMD:  return PH_CNT;
            default: return PH_WDATA;
        endcase
    endfunction

    assign receiving = (phase == PH_ADDR) || (phase == PH_CMD) ||
                       (phase == PH_CNT)  || (phase == PH_WDATA);
    assign byte_done = (bitcnt == BYTE_BITS) && !in_ack;
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign rd_bit    = rd_data[3'(4'd7 - bitcnt)];

    always_comb begin
        wr_req.en   = evt.scl_fall && (phase == PH_WDATA) && byte_done;
        wr_req.idx  = ptr;
        wr_req.data = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            in_ack <= 1'b0;
            rw_q   <= 1'b0;
            mnack  <= 1'b0;
            drv    <= 1'b0;
            bitcnt <= '0;
            shreg  <= '0;
            ptr    <= '0;
        end else if (evt.start) begin
            phase  <= PH_ADDR;
            in_ack <= 1'b0;
            bitcnt <= '0;
            ptr    <= '0;
            drv    <= 1'b0;
            mnack  <= 1'b0;
        end else if (evt.stop) begin
            phase  <= PH_IDLE;
            in_ack <= 1'b0;
            bitcnt <= '0;
            drv    <= 1'b0;
        end else if (evt.scl_rise && evt.scl) begin
            if (receiving && !in_ack) begin
                shreg  <= {shreg[6:0], evt.sda};
                bitcnt <= bitcnt + 4'd1;
            end else if (phase == PH_RDATA) begin
                if (!in_ack) begin
                    bitcnt <= bitcnt + 4'd1;
                end else begin
                    // master acknowledge bit
                    mnack <= evt.sda;
                    if (!evt.sda) begin
                        ptr <= ptr_step(ptr);
                    end
                end
            end
        end else if (evt.scl_fall) begin
            if (receiving) begin
                if (byte_done) begin
                    if ((phase == PH_ADDR) && !addr_hit) begin
                        phase <= PH_SKIP;
                        drv   <= 1'b0;
                    end else begin
                        in_ack <= 1'b1;
                        drv    <= 1'b1;
                        if (phase == PH_ADDR) begin
                            rw_q <= shreg[0];
                        end
                        if (phase == PH_WDATA) begin
                            ptr <= ptr_step(ptr);
                        end
                    end
                end else if (in_ack) begin
                    in_ack <= 1'b0;
                    bitcnt <= '0;
                    if ((phase == PH_ADDR) && rw_q) begin
                        phase <= PH_RDATA;
                        drv   <= ~rd_data[7];
                    end else begin
                        phase <= next_rx_phase(phase);
                        drv   <= 1'b0;
                    end
                end
            end else if (phase == PH_RDATA) begin
                if (!in_ack) begin
                    if (bitcnt == BYTE_BITS) begin
                        in_ack <= 1'b1;
                        drv    <= 1'b0;
                    end else begin
                        drv <= ~rd_bit;
                    end
                end else if (mnack) begin
                    phase  <= PH_SKIP;
                    in_ack <= 1'b0;
                    drv    <= 1'b0;
                end else begin
                    in_ack <= 1'b0;
                    bitcnt <= '0;
                    drv    <= ~rd_data[7];
                end
            end
        end
    end

    assign rd_idx        = ptr;
    assign sda_drive_low = drv;
    assign phase_o       = phase;

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0]       DEV_ADDR    = 7'h69,
    parameter int               SYNC_STAGES = 2,
    parameter logic [REG_W-1:0] ID_VALUE    = 8'h63
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scl_in,
    input  logic                      sda_in,
    output logic                      sda_drive_low,
    output logic [NUM_REGS*REG_W-1:0] cfg_regs
);

    line_evt_t        ev;
    wr_req_t          wr_req;
    logic [IDX_W-1:0] rd_idx;
    logic [REG_W-1:0] rd_data;
    phase_e           eng_phase;

    clkcfg_line_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (ev)
    );

    clkcfg_bus_engine #(
        .DEV_ADDR (DEV_ADDR)
    ) u_engine (
        .clk           (clk),
        .rst           (rst),
        .evt           (ev),
        .rd_data       (rd_data),
        .rd_idx        (rd_idx),
        .wr_req        (wr_req),
        .sda_drive_low (sda_drive_low),
        .phase_o       (eng_phase)
    );

    clkcfg_reg_store #(
        .ID_VALUE (ID_VALUE)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .all_regs (cfg_regs)
    );

endmodule

// File: rtl/clkcfg_checker.sv
module clkcfg_checker
    import clkcfg_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      scl_s,
    input logic                      start_evt,
    input logic                      stop_evt,
    input logic                      sda_drive_low,
    input phase_e                    phase,
    input logic [IDX_W-1:0]          ptr,
    input logic [NUM_REGS*REG_W-1:0] cfg_regs,
    input logic [REG_W-1:0]          id_value
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    // R1: a START always leads to address reception
    p_addr_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (phase == PH_ADDR));

    // R2: an ignoring slave never pulls the line
    p_skip_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !sda_drive_low);

    // R6: the pointer holds at the last register until a START
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ((ptr == LAST_IDX) && !start_evt) |=> (ptr == LAST_IDX));

    // R7: identification register is fixed
    p_id_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_regs[NUM_REGS*REG_W-1 -: REG_W] == id_value);

    // R8: bus conditions never alter stored registers
    p_regs_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (start_evt || stop_evt) |=> $stable(cfg_regs));

    // R10: drive turns on only while the sampled clock line is low
    p_drive_on_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> !$past(scl_s));

endmodule

bind clkcfg_i2c_slave clkcfg_checker u_checker (
    .clk           (clk),
    .rst           (rst),
    .scl_s         (ev.scl),
    .start_evt     (ev.start),
    .stop_evt      (ev.stop),
    .sda_drive_low (sda_drive_low),
    .phase         (eng_phase),
    .ptr           (rd_idx),
    .cfg_regs      (cfg_regs),
    .id_value      (ID_VALUE)
);

// File: tb/test_clkcfg_i2c_slave.sv
module test_clkcfg_i2c_slave;

    localparam int HALF     = 10;
    localparam int SETTLE   = 6;
    localparam int WATCHDOG = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_drive_low;
    logic [63:0] cfg_regs;
    wire         sda_line = m_sda & ~sda_drive_low;

    always #4 clk = ~clk;

    clkcfg_i2c_slave i_clkcfg_i2c_slave (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (m_scl),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .cfg_regs      (cfg_regs)
    );

    int          tests = 0;
    int          fails = 0;
    int          cyc = 0;
    int          last_chg = 0;
    int          r10_bad = 0;
    int          mptr = 0;
    logic [7:0]  mdl [8];
    logic        prev_drv = 1'b0;

    function automatic logic [7:0] dflt(int i);
        case (i)
            4: return 8'h45;
            5: return 8'hEF;
            6: return 8'h23;
            7: return 8'h63;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [63:0] mdl_image();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = mdl[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    // every settled clock: register image against the model, drive timing
    always @(negedge clk) begin
        if (!rst && (cyc - last_chg >= SETTLE)) begin
            chk(cfg_regs == mdl_image(), "R4 R6 R7 R8 register image", cfg_regs, mdl_image());
        end
        if (!rst && sda_drive_low && !prev_drv && m_scl) r10_bad++;
        prev_drv <= sda_drive_low;
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drv(input logic scl, input logic sda);
        m_scl = scl;
        m_sda = sda;
        last_chg = cyc;
    endtask

    task automatic bit_out(input logic b);
        drv(1'b0, b);
        step(HALF/2);
        drv(1'b1, b);
        step(HALF);
        drv(1'b0, b);
        step(HALF/2);
    endtask

    task automatic bit_in(output logic b);
        drv(1'b0, 1'b1);
        step(HALF/2);
        drv(1'b1, 1'b1);
        step(HALF/2);
        b = sda_line;
        step(HALF/2);
        drv(1'b0, 1'b1);
        step(HALF/2);
    endtask

    task automatic bus_start();
        if (m_scl == 1'b0) begin
            drv(1'b0, 1'b1);
            step(HALF/2);
            drv(1'b1, 1'b1);
            step(HALF/2);
        end
        drv(1'b1, 1'b0);
        step(HALF/2);
        drv(1'b0, 1'b0);
        step(HALF/2);
        mptr = 0;
    endtask

    task automatic bus_stop();
        drv(1'b0, 1'b0);
        step(HALF/2);
        drv(1'b1, 1'b0);
        step(HALF/2);
        drv(1'b1, 1'b1);
        step(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] v, input bit store, output bit acked);
        logic a;
        for (int i = 7; i >= 1; i--) bit_out(v[i]);
        drv(1'b0, v[0]);
        step(HALF/2);
        drv(1'b1, v[0]);
        step(HALF);
        drv(1'b0, v[0]);
        if (store) begin
            if (mptr < 7) begin
                mdl[mptr] = v;
                mptr++;
            end
        end
        step(HALF/2);
        bit_in(a);
        acked = !a;
    endtask

    task automatic rd_byte(input bit master_nack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(master_nack);
    endtask

    task automatic power_reset();
        rst = 1'b1;
        for (int i = 0; i < 8; i++) mdl[i] = dflt(i);
        mptr = 0;
        step(4);
        rst = 1'b0;
        last_chg = cyc;
        step(SETTLE + 2);
    endtask

    task automatic write_seq(input logic [7:0] data [], input string tag);
        bit a;
        bus_start();
        wr_byte(8'hD2, 1'b0, a);
        chk(a, {tag, " R2 write address ack"}, a, 1);
        wr_byte(8'h5A, 1'b0, a);
        chk(a, {tag, " R3 command byte ack"}, a, 1);
        wr_byte(8'h03, 1'b0, a);
        chk(a, {tag, " R3 count byte ack"}, a, 1);
        foreach (data[i]) begin
            wr_byte(data[i], 1'b1, a);
            chk(a, {tag, " R4 data byte ack"}, a, 1);
        end
        bus_stop();
    endtask

    task automatic read_seq(input int n, input string tag);
        bit         a;
        logic [7:0] v;
        bus_start();
        wr_byte(8'hD3, 1'b0, a);
        chk(a, {tag, " R2 read address ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i == n - 1, v);
            chk(v == mdl[(i < 7) ? i : 7], (i < 7) ? {tag, " R5 read byte"} : {tag, " R6 read past end"},
                v, mdl[(i < 7) ? i : 7]);
        end
        step(SETTLE);
        chk(!sda_drive_low, {tag, " R9 released after master NACK"}, sda_drive_low, 0);
    endtask

    initial begin
        logic [7:0] dat [];
        logic [7:0] v;
        logic       b;
        bit         a;

        power_reset();
        chk(cfg_regs == 64'h6323EF4500000000, "R8 power-up image", cfg_regs, 64'h6323EF4500000000);
        chk(!sda_drive_low, "R8 idle drive", sda_drive_low, 0);

        // plain write of three registers
        dat = '{8'h11, 8'h22, 8'h33};
        write_seq(dat, "wr3");
        chk(cfg_regs[23:0] == 24'h332211, "R3 R4 filler bytes not stored", cfg_regs[23:0], 24'h332211);

        // read back five registers, NACK on the last
        read_seq(5, "rd5");
        bit_in(b);
        chk(b == 1'b1, "R9 slave silent after NACK", b, 1);
        bus_stop();

        // wrong address: NACK, then ignored
        bus_start();
        wr_byte(8'hA4, 1'b0, a);
        chk(!a, "R2 foreign address nack", a, 0);
        wr_byte(8'h00, 1'b0, a);
        chk(!a, "R2 ignored byte 1", a, 0);
        wr_byte(8'h00, 1'b0, a);
        chk(!a, "R2 ignored byte 2", a, 0);
        wr_byte(8'h77, 1'b0, a);
        chk(!a, "R2 ignored byte 3", a, 0);
        bus_stop();
        chk(cfg_regs[7:0] == 8'h11, "R2 foreign write dropped", cfg_regs[7:0], 8'h11);

        // pointer saturation on write
        dat = new[10];
        for (int i = 0; i < 10; i++) dat[i] = 8'hA0 + 8'(i);
        write_seq(dat, "sat");
        chk(cfg_regs[15:0] == 16'hA1A0, "R6 no wrap to register 0", cfg_regs[15:0], 16'hA1A0);
        chk(cfg_regs[55:48] == 8'hA6, "R4 register 6 written", cfg_regs[55:48], 8'hA6);
        chk(cfg_regs[63:56] == 8'h63, "R7 identification unchanged", cfg_regs[63:56], 8'h63);

        // read beyond the last register
        read_seq(10, "rd10");
        bus_stop();

        // repeated START from write into read
        bus_start();
        wr_byte(8'hD2, 1'b0, a);
        wr_byte(8'h00, 1'b0, a);
        wr_byte(8'h00, 1'b0, a);
        wr_byte(8'h5C, 1'b1, a);
        chk(a, "R1 data before restart ack", a, 1);
        bus_start();
        wr_byte(8'hD3, 1'b0, a);
        chk(a, "R1 read address after restart", a, 1);
        rd_byte(1'b0, v);
        chk(v == 8'h5C, "R1 restart reads register 0", v, 8'h5C);
        rd_byte(1'b1, v);
        chk(v == 8'hA1, "R1 restart reads register 1", v, 8'hA1);
        bus_stop();

        // STOP mid-write restarts pointer on the next transfer
        dat = '{8'h99};
        write_seq(dat, "stopA");
        dat = '{8'h98};
        write_seq(dat, "stopB");
        chk(cfg_regs[15:0] == 16'hA198, "R1 pointer restarts after STOP", cfg_regs[15:0], 16'hA198);

        // only filler bytes, then STOP
        dat = new[0];
        write_seq(dat, "fill");
        chk(cfg_regs == mdl_image(), "R3 filler-only write", cfg_regs, mdl_image());
        chk(cfg_regs[7:0] == 8'h98, "R8 STOP keeps registers", cfg_regs[7:0], 8'h98);

        // true power-up reset restores defaults
        power_reset();
        chk(cfg_regs == 64'h6323EF4500000000, "R8 defaults after power reset", cfg_regs, 64'h6323EF4500000000);

        chk(r10_bad == 0, "R10 drive turned on with SCL high", r10_bad, 0);

        summary();
        $finish;
    end

endmodule